// File: doc/BRIEF.md
# Shared Bus-Port Arbiter for Fetch, Load/Store and Debugger Access

This block lets three requesters share one AHB5 manager port that issues single transfers only. The requesters are the instruction fetch path, the core's load/store/atomic path and a debugger system-bus-access channel. A fixed priority picks at most one request per cycle and places it in a registered address phase. The owner of each transfer is carried into the data phase, so that read data, error status and exclusive status go back to the requester that issued it, even while the subordinate holds `hready` low.

Each transfer's sideband signals follow from who issued it. `hprot` carries the privilege and tells fetch apart from data access. `hmaster` tells core traffic apart from debugger traffic. `hexcl` is raised only for the two halves of an exclusive read-modify-write. Write data is copied across the byte lanes that the size and low address bits select. When an error response arrives, the port withdraws the waiting address phase for one cycle and issues it again afterwards.

Top module: `ahb_shared_mgr`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `htrans` is IDLE (0), and no grant and no response strobe is high while no request is present.
- R2: `htrans` only takes the values 0 (IDLE) and 2 (NONSEQ). `hburst` is 0 and `hmastlock` is 0. A NONSEQ transfer has `hsize` 0, 1 or 2 (byte, halfword, word) and an address aligned to that size.
- R3: Load/store has priority over the debugger channel, which has priority over fetch. At most one grant is high per cycle, and a requester that loses keeps its grant low until it wins.
- R4: A request granted in one cycle appears as NONSEQ in the next cycle, with the requested address, direction and size. These stay stable while `hready` is low, unless an error response is in progress.
- R5: `hprot[3:2]` is 0. `hprot[1]` is the requester's privilege input for fetch and load/store, and always 1 for debugger transfers. `hprot[0]` is 0 for fetch and 1 for load/store and debugger transfers.
- R6: `hmaster` is `CORE_ID` (default 0x00) for fetch and load/store transfers and `SBA_ID` (default 0x01) for debugger transfers.
- R7: `hexcl` is high only on NONSEQ load/store transfers whose exclusive flag was set. `hexokay` is returned to load/store with the response of that transfer.
- R8: In the data phase of a write, a byte is copied to all four lanes of `hwdata` and a halfword to both halves, so the lanes picked by `haddr[1:0]` and `hsize` carry the data. `hwdata` is held while `hready` is low.
- R9: Exactly one response strobe, the one for the owner of the data phase, is high in the cycle where that data phase ends with `hready` high. It carries `hrdata` as the read data. Responses arrive in grant order.
- R10: On the first cycle of an error response (`hresp` high, `hready` low), the next cycle shows `htrans` IDLE. The owner sees its error flag with its response strobe, and an address phase that was waiting is issued afterwards without being lost.
- R11: Fetch transfers are always word-sized reads on a word-aligned address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_req | input | 1 | Fetch request |
| if_addr | input | ADDR_W | Fetch address, word aligned |
| if_priv | input | 1 | Fetch privilege (1 = machine/debug) |
| if_gnt | output | 1 | Fetch request accepted this cycle |
| if_rsp | output | 1 | Fetch response strobe |
| if_err | output | 1 | Fetch bus error, valid with if_rsp |
| if_rdata | output | 32 | Fetch read data |
| ls_req | input | 1 | Load/store request |
| ls_addr | input | ADDR_W | Load/store address |
| ls_write | input | 1 | Load/store direction (1 = write) |
| ls_size | input | 2 | Load/store size (0/1/2 = byte/half/word) |
| ls_wdata | input | 32 | Load/store write data, LSB aligned |
| ls_priv | input | 1 | Load/store privilege |
| ls_excl | input | 1 | Exclusive access flag |
| ls_gnt | output | 1 | Load/store request accepted |
| ls_rsp | output | 1 | Load/store response strobe |
| ls_err | output | 1 | Load/store bus error |
| ls_exokay | output | 1 | Exclusive success status |
| ls_rdata | output | 32 | Load/store read data |
| sba_vld | input | 1 | Debugger request |
| sba_addr | input | ADDR_W | Debugger address |
| sba_write | input | 1 | Debugger direction |
| sba_size | input | 2 | Debugger size (0/1/2 = byte/half/word) |
| sba_wdata | input | 32 | Debugger write data |
| sba_rdy | output | 1 | Debugger request accepted |
| sba_rsp | output | 1 | Debugger response strobe |
| sba_err | output | 1 | Debugger bus error |
| sba_rdata | output | 32 | Debugger read data |
| haddr | output | ADDR_W | Bus address |
| hwrite | output | 1 | Bus direction |
| htrans | output | 2 | Transfer type |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type, always single |
| hprot | output | 4 | Protection attributes |
| hmastlock | output | 1 | Locked transfer, always 0 |
| hmaster | output | 8 | Manager identifier |
| hexcl | output | 1 | Exclusive transfer |
| hwdata | output | 32 | Write data |
| hready | input | 1 | Transfer done / stall |
| hresp | input | 1 | Error response |
| hexokay | input | 1 | Exclusive okay |
| hrdata | input | 32 | Read data |

## Verification
The bench builds the block with its default parameters: a 32-bit address, core ID 0x00 and debugger ID 0x01. With these, the exact `hmaster` codes and the lane copying of 32-bit data can be compared literally. A subordinate model with a wait-state count that can be changed at run time brings a waiting address phase behind a stalled data phase within reach. The same model raises two-cycle errors on any address with bit 31 set, so the withdrawn and reissued address phase can be observed. It also reports exclusive success from address bit 3, so both exclusive outcomes are exercised.

// File: rtl/ahb_shared_mgr.sv
module ahb_shared_mgr #(
  parameter int         ADDR_W  = 32,
  parameter logic [7:0] CORE_ID = 8'h00,
  parameter logic [7:0] SBA_ID  = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_req,
  input  logic [ADDR_W-1:0] if_addr,
  input  logic              if_priv,
  output logic              if_gnt,
  output logic              if_rsp,
  output logic              if_err,
  output logic [31:0]       if_rdata,
  input  logic              ls_req,
  input  logic [ADDR_W-1:0] ls_addr,
  input  logic              ls_write,
  input  logic [1:0]        ls_size,
  input  logic [31:0]       ls_wdata,
  input  logic              ls_priv,
  input  logic              ls_excl,
  output logic              ls_gnt,
  output logic              ls_rsp,
  output logic              ls_err,
  output logic              ls_exokay,
  output logic [31:0]       ls_rdata,
  input  logic              sba_vld,
  input  logic [ADDR_W-1:0] sba_addr,
  input  logic              sba_write,
  input  logic [1:0]        sba_size,
  input  logic [31:0]       sba_wdata,
  output logic              sba_rdy,
  output logic              sba_rsp,
  output logic              sba_err,
  output logic [31:0]       sba_rdata,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [1:0]        htrans,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [3:0]        hprot,
  output logic              hmastlock,
  output logic [7:0]        hmaster,
  output logic              hexcl,
  output logic [31:0]       hwdata,
  input  logic              hready,
  input  logic              hresp,
  input  logic              hexokay,
  input  logic [31:0]       hrdata
);
  localparam logic [1:0] SRC_IF  = 2'd0;
  localparam logic [1:0] SRC_LS  = 2'd1;
  localparam logic [1:0] SRC_SBA = 2'd2;
  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_NSEQ = 2'b10;

  logic              a_vld, a_write, a_priv, a_excl;
  logic [1:0]        a_src, a_size;
  logic [ADDR_W-1:0] a_addr;
  logic [31:0]       a_wdata, a_lanes;
  logic              d_vld, err_hold;
  logic [1:0]        d_src;
  logic [31:0]       d_wdata;
  logic              load_ok, d_done;

  assign load_ok = !a_vld || (hready && !err_hold);

  assign ls_gnt  = ls_req && load_ok;
  assign sba_rdy = sba_vld && !ls_req && load_ok;
  assign if_gnt  = if_req && !ls_req && !sba_vld && load_ok;

  assign a_lanes = (a_size == 2'd0) ? {4{a_wdata[7:0]}} :
                   (a_size == 2'd1) ? {2{a_wdata[15:0]}} : a_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld    <= 1'b0;
      a_src    <= SRC_IF;
      a_addr   <= '0;
      a_write  <= 1'b0;
      a_size   <= 2'd0;
      a_wdata  <= '0;
      a_priv   <= 1'b0;
      a_excl   <= 1'b0;
      d_vld    <= 1'b0;
      d_src    <= SRC_IF;
      d_wdata  <= '0;
      err_hold <= 1'b0;
    end else begin
      err_hold <= d_vld && hresp && !hready;
      if (hready) begin
        d_vld   <= a_vld && !err_hold;
        d_src   <= a_src;
        d_wdata <= a_lanes;
      end
      if (ls_gnt) begin
        a_vld   <= 1'b1;
        a_src   <= SRC_LS;
        a_addr  <= ls_addr;
        a_write <= ls_write;
        a_size  <= ls_size;
        a_wdata <= ls_wdata;
        a_priv  <= ls_priv;
        a_excl  <= ls_excl;
      end else if (sba_rdy) begin
        a_vld   <= 1'b1;
        a_src   <= SRC_SBA;
        a_addr  <= sba_addr;
        a_write <= sba_write;
        a_size  <= sba_size;
        a_wdata <= sba_wdata;
        a_priv  <= 1'b1;
        a_excl  <= 1'b0;
      end else if (if_gnt) begin
        a_vld   <= 1'b1;
        a_src   <= SRC_IF;
        a_addr  <= if_addr;
        a_write <= 1'b0;
        a_size  <= 2'd2;
        a_wdata <= '0;
        a_priv  <= if_priv;
        a_excl  <= 1'b0;
      end else if (load_ok) begin
        a_vld <= 1'b0;
      end
    end
  end

  assign htrans    = (a_vld && !err_hold) ? TR_NSEQ : TR_IDLE;
  assign haddr     = a_addr;
  assign hwrite    = a_write;
  assign hsize     = {1'b0, a_size};
  assign hburst    = 3'b000;
  assign hmastlock = 1'b0;
  assign hprot     = {2'b00, a_priv, a_src != SRC_IF};
  assign hmaster   = (a_src == SRC_SBA) ? SBA_ID : CORE_ID;
  assign hexcl     = htrans[1] && a_excl;
  assign hwdata    = d_wdata;

  assign d_done    = d_vld && hready;
  assign if_rsp    = d_done && d_src == SRC_IF;
  assign ls_rsp    = d_done && d_src == SRC_LS;
  assign sba_rsp   = d_done && d_src == SRC_SBA;
  assign if_err    = if_rsp && hresp;
  assign ls_err    = ls_rsp && hresp;
  assign sba_err   = sba_rsp && hresp;
  assign ls_exokay = ls_rsp && hexokay;
  assign if_rdata  = hrdata;
  assign ls_rdata  = hrdata;
  assign sba_rdata = hrdata;
endmodule

// File: rtl/ahb_shared_mgr_chk.sv
module ahb_shared_mgr_chk #(
  parameter int         ADDR_W  = 32,
  parameter logic [7:0] CORE_ID = 8'h00,
  parameter logic [7:0] SBA_ID  = 8'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] haddr,
  input logic              hwrite,
  input logic [1:0]        htrans,
  input logic [2:0]        hsize,
  input logic [3:0]        hprot,
  input logic [7:0]        hmaster,
  input logic              hexcl,
  input logic              hready,
  input logic              hresp,
  input logic              ls_req,
  input logic              sba_vld,
  input logic              ls_gnt,
  input logic              sba_rdy,
  input logic              if_gnt,
  input logic              if_rsp,
  input logic              ls_rsp,
  input logic              sba_rsp
);
  // R2
  htrans_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    htrans == 2'd0 || htrans == 2'd2);

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    htrans == 2'd2 |-> (hsize == 3'd0) || (hsize == 3'd1 && !haddr[0]) ||
                       (hsize == 3'd2 && haddr[1:0] == 2'b00));

  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ls_gnt, sba_rdy, if_gnt}));

  // R3
  grant_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_req && (sba_rdy || if_gnt)) && !(sba_vld && if_gnt));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'd2 && !hready && !hresp) |=>
      (htrans == 2'd2 && $stable(haddr) && $stable(hsize) && $stable(hwrite)));

  // R5
  sba_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'd2 && hmaster == SBA_ID) |-> hprot == 4'b0011);

  // R7
  excl_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hexcl |-> (hprot[0] && hmaster == CORE_ID && htrans == 2'd2));

  // R9
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({if_rsp, ls_rsp, sba_rsp}));

  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && !hready) |=> htrans == 2'd0);

  // R11
  fetch_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'd2 && !hprot[0]) |-> (hsize == 3'd2 && !hwrite && haddr[1:0] == 2'b00));
endmodule

bind ahb_shared_mgr ahb_shared_mgr_chk #(
  .ADDR_W(ADDR_W), .CORE_ID(CORE_ID), .SBA_ID(SBA_ID)
) u_chk (.*);

// File: tb/sim_ahb_shared_mgr.sv
`timescale 1ns/100ps
module sim_ahb_shared_mgr;
  localparam logic [1:0] S_IF = 2'd0, S_LS = 2'd1, S_SBA = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic if_req = 0, if_priv = 0, ls_req = 0, ls_write = 0, ls_priv = 0, ls_excl = 0;
  logic sba_vld = 0, sba_write = 0;
  logic [31:0] if_addr = 0, ls_addr = 0, ls_wdata = 0, sba_addr = 0, sba_wdata = 0;
  logic [1:0] ls_size = 0, sba_size = 0;
  logic if_gnt, if_rsp, if_err, ls_gnt, ls_rsp, ls_err, ls_exokay, sba_rdy, sba_rsp, sba_err;
  logic [31:0] if_rdata, ls_rdata, sba_rdata, haddr, hwdata;
  logic hwrite, hmastlock, hexcl;
  logic [1:0] htrans;
  logic [2:0] hsize, hburst;
  logic [3:0] hprot;
  logic [7:0] hmaster;
  logic hready = 1'b1, hresp = 1'b0, hexokay = 1'b0;
  logic [31:0] hrdata = 32'h0;

  ahb_shared_mgr u0 (.*);

  typedef struct { logic [31:0] addr; logic wr; logic [2:0] size; logic [3:0] prot;
                   logic [7:0] mst; logic excl; } aexp_t;
  typedef struct { logic [1:0] src; logic wr; logic err; logic [31:0] rdata;
                   logic [31:0] wd; logic [31:0] mask; logic ex; logic exok; } dexp_t;
  aexp_t aq[$];
  dexp_t dq[$];
  logic [1:0] grant_log[$];
  logic [31:0] refm [16];
  logic [31:0] smem [16];
  int n_chk = 0, n_fail = 0, wait_cfg = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] lane_mask(logic [1:0] lo, logic [1:0] sz);
    if (sz == 2'd0) return 32'hFF << (8 * lo);
    if (sz == 2'd1) return 32'hFFFF << (16 * lo[1]);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] repl(logic [31:0] d, logic [1:0] sz);
    if (sz == 2'd0) return {4{d[7:0]}};
    if (sz == 2'd1) return {2{d[15:0]}};
    return d;
  endfunction

  task automatic push_exp(logic [1:0] src, logic [31:0] a, logic w, logic [1:0] s,
                          logic [31:0] d, logic p, logic e);
    aexp_t ae;
    dexp_t de;
    ae.addr = a; ae.wr = w; ae.size = {1'b0, s};
    ae.prot = {2'b00, (src == S_SBA) ? 1'b1 : p, src != S_IF};
    ae.mst  = (src == S_SBA) ? 8'h01 : 8'h00;
    ae.excl = (src == S_LS) && e;
    aq.push_back(ae);
    de.src = src; de.wr = w; de.err = a[31];
    de.mask = lane_mask(a[1:0], s);
    de.wd = repl(d, s);
    de.rdata = refm[a[5:2]];
    de.ex = ae.excl; de.exok = !a[3];
    if (w && !a[31]) refm[a[5:2]] = (refm[a[5:2]] & ~de.mask) | (de.wd & de.mask);
    dq.push_back(de);
    grant_log.push_back(src);
  endtask

  task automatic do_ls(logic [31:0] a, logic w, logic [1:0] s, logic [31:0] d, logic p, logic e);
    @(negedge clk);
    ls_req = 1; ls_addr = a; ls_write = w; ls_size = s; ls_wdata = d; ls_priv = p; ls_excl = e;
    while (1) begin
      #1;
      if (ls_gnt) break;
      @(negedge clk);
    end
    push_exp(S_LS, a, w, s, d, p, e);
    @(negedge clk);
    ls_req = 0;
  endtask

  task automatic do_sba(logic [31:0] a, logic w, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    sba_vld = 1; sba_addr = a; sba_write = w; sba_size = s; sba_wdata = d;
    while (1) begin
      #1;
      if (sba_rdy) break;
      @(negedge clk);
    end
    push_exp(S_SBA, a, w, s, d, 1'b1, 1'b0);
    @(negedge clk);
    sba_vld = 0;
  endtask

  task automatic do_if(logic [31:0] a, logic p);
    @(negedge clk);
    if_req = 1; if_addr = a; if_priv = p;
    while (1) begin
      #1;
      if (if_gnt) break;
      @(negedge clk);
    end
    push_exp(S_IF, a, 1'b0, 2'd2, 32'h0, p, 1'b0);
    @(negedge clk);
    if_req = 0;
  endtask

  // subordinate model
  logic dp_vld = 0, dp_wr = 0;
  logic [31:0] dp_addr = 0;
  logic [1:0] dp_sz = 0;
  int cnt = 0;
  bit eph = 0;
  always begin
    logic [1:0] c_trans;
    logic [31:0] c_addr, c_wd;
    logic c_wr, c_rdy;
    logic [2:0] c_sz;
    logic [31:0] m;
    @(negedge clk);
    hresp = 0; hready = 1; hexokay = !dp_addr[3]; hrdata = 32'h0;
    if (dp_vld) begin
      if (cnt > 0) hready = 0;
      else if (dp_addr[31]) begin hresp = 1; hready = eph; end
      else if (!dp_wr) hrdata = smem[dp_addr[5:2]];
    end
    #1;
    c_trans = htrans; c_addr = haddr; c_wr = hwrite; c_sz = hsize; c_wd = hwdata; c_rdy = hready;
    @(posedge clk);
    if (!rst_n) begin
      dp_vld = 0; cnt = 0; eph = 0;
    end else if (c_rdy) begin
      if (dp_vld && dp_wr && !dp_addr[31]) begin
        m = lane_mask(dp_addr[1:0], dp_sz);
        smem[dp_addr[5:2]] = (smem[dp_addr[5:2]] & ~m) | (c_wd & m);
      end
      dp_vld = (c_trans == 2'd2); dp_addr = c_addr; dp_wr = c_wr; dp_sz = c_sz[1:0];
      cnt = wait_cfg; eph = 0;
    end else if (cnt > 0) cnt--;
    else eph = 1;
  end

  // monitor
  always begin
    bit prev_err;
    aexp_t ae;
    dexp_t de;
    logic [1:0] a_src;
    logic a_err, a_exok;
    logic [31:0] a_rd;
    prev_err = 0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (prev_err) chk(htrans == 2'd0, "R10 idle after error", {30'h0, htrans}, 32'h0);
        prev_err = hresp && !hready;
        if (htrans == 2'd2 && hready) begin
          if (aq.size() == 0) chk(0, "R4 unexpected transfer", haddr, 32'h0);
          else begin
            ae = aq.pop_front();
            chk(haddr == ae.addr, "R4 haddr", haddr, ae.addr);
            chk(hwrite == ae.wr && hsize == ae.size, "R4 dir/size", {28'h0, hwrite, hsize},
                {28'h0, ae.wr, ae.size});
            chk(hburst == 3'd0 && hmastlock == 1'b0, "R2 burst/lock", {28'h0, hmastlock, hburst}, 32'h0);
            chk(hprot == ae.prot, "R5 hprot", {28'h0, hprot}, {28'h0, ae.prot});
            chk(hmaster == ae.mst, "R6 hmaster", {24'h0, hmaster}, {24'h0, ae.mst});
            chk(hexcl == ae.excl, "R7 hexcl", {31'h0, hexcl}, {31'h0, ae.excl});
            if (ae.prot[0] == 1'b0)
              chk(hsize == 3'd2 && !hwrite, "R11 fetch shape", {28'h0, hwrite, hsize}, 32'h2);
          end
        end
        if (if_rsp || ls_rsp || sba_rsp) begin
          a_src = ls_rsp ? S_LS : (sba_rsp ? S_SBA : S_IF);
          a_err = ls_rsp ? ls_err : (sba_rsp ? sba_err : if_err);
          a_rd  = ls_rsp ? ls_rdata : (sba_rsp ? sba_rdata : if_rdata);
          a_exok = ls_exokay;
          if (dq.size() == 0) chk(0, "R9 unexpected response", {30'h0, a_src}, 32'h0);
          else begin
            de = dq.pop_front();
            chk(a_src == de.src, "R9 response owner", {30'h0, a_src}, {30'h0, de.src});
            chk(a_err == de.err, de.err ? "R10 error flag" : "R9 error flag",
                {31'h0, a_err}, {31'h0, de.err});
            if (!de.wr && !de.err) chk(a_rd == de.rdata, "R9 read data", a_rd, de.rdata);
            if (de.wr) chk((hwdata & de.mask) == (de.wd & de.mask), "R8 write lanes",
                           hwdata, de.wd);
            if (de.ex) chk(a_exok == de.exok, "R7 exokay", {31'h0, a_exok}, {31'h0, de.exok});
          end
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      refm[i] = 32'hA500_0000 + i * 32'h0101_0101;
      smem[i] = refm[i];
    end
    repeat (3) @(negedge clk);
    #1;
    chk(htrans == 2'd0, "R1 idle in reset", {30'h0, htrans}, 32'h0);
    chk({if_gnt, ls_gnt, sba_rdy, if_rsp, ls_rsp, sba_rsp} == 6'b0, "R1 strobes in reset",
        {26'h0, if_gnt, ls_gnt, sba_rdy, if_rsp, ls_rsp, sba_rsp}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(htrans == 2'd0, "R1 idle after reset", {30'h0, htrans}, 32'h0);

    do_if(32'h0000_0004, 1'b1);
    do_ls(32'h10, 1'b1, 2'd2, 32'h1122_3344, 1'b1, 1'b0);
    do_ls(32'h11, 1'b1, 2'd0, 32'h0000_00AB, 1'b1, 1'b0);
    do_ls(32'h12, 1'b1, 2'd1, 32'h0000_CDEF, 1'b0, 1'b0);
    do_ls(32'h10, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
    do_sba(32'h20, 1'b1, 2'd2, 32'hDEAD_BEEF);
    do_sba(32'h23, 1'b1, 2'd0, 32'h0000_0077);
    do_sba(32'h20, 1'b0, 2'd2, 32'h0);
    do_sba(32'h22, 1'b0, 2'd1, 32'h0);
    do_if(32'h0000_0008, 1'b0);

    grant_log.delete();
    fork
      do_ls(32'h30, 1'b0, 2'd2, 32'h0, 1'b1, 1'b0);
      do_sba(32'h34, 1'b0, 2'd2, 32'h0);
      do_if(32'h38, 1'b0);
    join
    chk(grant_log.size() == 3, "R3 grant count", grant_log.size(), 3);
    if (grant_log.size() == 3) begin
      chk(grant_log[0] == S_LS, "R3 first winner", {30'h0, grant_log[0]}, {30'h0, S_LS});
      chk(grant_log[1] == S_SBA, "R3 second winner", {30'h0, grant_log[1]}, {30'h0, S_SBA});
      chk(grant_log[2] == S_IF, "R3 last winner", {30'h0, grant_log[2]}, {30'h0, S_IF});
    end

    wait_cfg = 2;
    fork
      do_ls(32'h14, 1'b1, 2'd2, 32'h55AA_0FF0, 1'b1, 1'b0);
      do_if(32'h18, 1'b1);
    join
    fork
      do_sba(32'h14, 1'b0, 2'd2, 32'h0);
      do_ls(32'h17, 1'b1, 2'd0, 32'h0000_0042, 1'b0, 1'b0);
    join
    do_ls(32'h14, 1'b0, 2'd2, 32'h0, 1'b1, 1'b0);

    wait_cfg = 0;
    fork
      do_ls(32'h8000_0010, 1'b0, 2'd2, 32'h0, 1'b1, 1'b0);
      do_if(32'h3C, 1'b1);
    join
    wait_cfg = 1;
    fork
      do_sba(32'h8000_0004, 1'b1, 2'd2, 32'h0000_0001);
      do_ls(32'h1C, 1'b0, 2'd2, 32'h0, 1'b1, 1'b0);
    join

    wait_cfg = 0;
    do_ls(32'h20, 1'b0, 2'd2, 32'h0, 1'b1, 1'b1);
    do_ls(32'h28, 1'b1, 2'd2, 32'h0000_0099, 1'b1, 1'b1);
    do_ls(32'h28, 1'b0, 2'd2, 32'h0, 1'b1, 1'b0);

    repeat (8) @(negedge clk);
    #1;
    chk(aq.size() == 0 && dq.size() == 0, "R9 all responses returned",
        aq.size() + dq.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog act=hung exp=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule